// File: doc/BRIEF.md
# UART Host Register File and Interrupt Identification

This block is the host-facing register bank of a serial controller that is compatible with the 16450 and 16550. A host reaches eight byte-wide locations through a 3-bit offset, a write strobe and a read strobe. One bit in the line control register is the divisor-latch select. When it is set, offsets 0 and 1 become the low and high bytes of the baud divisor. When it is clear, those offsets are the data port and the interrupt enable register. Offset 2 returns the interrupt identification on a read and loads the FIFO control register on a write.

Four interrupt causes are collected here: line errors, received data, transmit holding empty, and modem line changes. The highest-ranked cause that is enabled appears in the identification byte and drives the interrupt pin. The shifters, baud counter and FIFO storage are outside this block. They connect through plain status inputs, event pulses, and one-cycle strobes for pop, push and flush.

Top module: `uart_regfile`

## Requirements
- R1: After reset the interrupt enable, line control, modem control and scratch registers read 0x00, the divisor output is 0x0000, FIFO mode is off, the identification byte reads 0x01 and `irq` is low.
- R2: With line control bit 7 set, writes to offsets 0 and 1 load the low and high divisor bytes, and reads of those offsets return them. The interrupt enable register is left unchanged.
- R3: With line control bit 7 clear, a read of offset 0 returns `rx_data` and raises `rx_pop` for that cycle. A write to offset 0 raises `tx_push` with `tx_data` equal to the written byte.
- R4: The interrupt enable register keeps bits 3:0 and always reads 0 in bits 7:4. Bit 0 enables received data, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status.
- R5: Line control (offset 3, 8 bits), modem control (offset 4, bits 4:0, with bits 7:5 reading 0) and scratch (offset 7, 8 bits) read back what was written.
- R6: A write to offset 2 sets FIFO mode from bit 0. The identification byte reads bits 7:6 as 11 in FIFO mode and 00 in character mode, and bit 3 always reads 0.
- R7: Identification bit 0 reads 0 while an enabled cause is pending and 1 otherwise.
- R8: Causes are ranked from highest to lowest as line status (ID 011), received data (ID 010), transmit empty (ID 001) and modem status (ID 000). The ID of the highest pending cause is placed in identification bits 3:1.
- R9: The transmit-empty cause is set when `thr_empty` rises, or when bit 1 of the interrupt enable register is written from 0 to 1 while `thr_empty` is high. It is cleared by a write to the data port, or by a read of the identification byte while that byte reports ID 001.
- R10: Line status at offset 5 reads {0, `tx_idle`, `thr_empty`, error[3:0], `rx_ready`}. Each `line_err` pulse sets a sticky error bit: bit 0 for overrun, bit 1 for parity, bit 2 for framing and bit 3 for break. A read of offset 5 clears the sticky bits.
- R11: Modem status at offset 6 reads {`modem_in`[3:0], change[3:0]}, where `modem_in` is {dcd, ri, dsr, cts}. A change bit is set whenever its line differs from its value in the previous cycle. A read of offset 6 clears the change bits.
- R12: `irq` is high exactly when an enabled cause is pending. A cause that is pending but disabled raises neither `irq` nor an ID.
- R13: A write to offset 2 with bit 1 set raises `rx_flush` for that cycle, and with bit 2 set raises `tx_flush` for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects at the clock edge) |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| rx_data | input | 8 | Byte at the head of the receive path |
| rx_ready | input | 1 | Received data available |
| rx_pop | output | 1 | Receive byte consumed |
| tx_data | output | 8 | Byte for the transmit path |
| tx_push | output | 1 | Transmit byte strobe |
| thr_empty | input | 1 | Transmit holding storage empty |
| tx_idle | input | 1 | Transmitter fully idle |
| line_err | input | 4 | Error pulses {break, framing, parity, overrun} |
| modem_in | input | 4 | Modem lines {dcd, ri, dsr, cts} |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control register |
| modem_ctrl | output | 5 | Modem control register |
| fifo_en | output | 1 | FIFO mode active |
| rx_flush | output | 1 | Receive FIFO flush strobe |
| tx_flush | output | 1 | Transmit FIFO flush strobe |

## Verification
The bench raises all four causes at once. It then retires them one at a time and reads the identification byte after each step. A wrong ranking, or a clear on the wrong read, shows up as an unexpected ID or a pending flag that stays set. It also covers divisor steering: a design that ignores the select bit would overwrite the interrupt enable register or return the receive byte in place of the divisor. Further checks cover the sticky error and change bits across two successive status reads, the transmit-empty cause raised by an enable write alone, and the FIFO-mode bits 7:6 with the flush strobes.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int N_SRC = 4;
    localparam int N_ERR = 4;
    localparam int N_MDM = 4;
    localparam int IER_W = 4;
    localparam int MCR_W = 5;

    localparam logic [AW-1:0] OFS_DATA = 3'd0;
    localparam logic [AW-1:0] OFS_IER  = 3'd1;
    localparam logic [AW-1:0] OFS_IIR  = 3'd2;
    localparam logic [AW-1:0] OFS_LCR  = 3'd3;
    localparam logic [AW-1:0] OFS_MCR  = 3'd4;
    localparam logic [AW-1:0] OFS_LSR  = 3'd5;
    localparam logic [AW-1:0] OFS_MSR  = 3'd6;
    localparam logic [AW-1:0] OFS_SCR  = 3'd7;

    // source index equals its enable bit position
    localparam int SRC_RDA  = 0;
    localparam int SRC_THRE = 1;
    localparam int SRC_RLS  = 2;
    localparam int SRC_MSR  = 3;

    typedef enum logic [2:0] {
        IID_MSR  = 3'b000,
        IID_THRE = 3'b001,
        IID_RDA  = 3'b010,
        IID_RLS  = 3'b011
    } iid_e;

    // highest rank first
    localparam int PRIO_RANK [N_SRC] = '{SRC_RLS, SRC_RDA, SRC_THRE, SRC_MSR};

    function automatic iid_e src_to_iid(input int src);
        case (src)
            SRC_RLS:  return IID_RLS;
            SRC_RDA:  return IID_RDA;
            SRC_THRE: return IID_THRE;
            default:  return IID_MSR;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_reg_pkg::*;
(
    input  logic [N_SRC-1:0] ien,
    input  logic [N_SRC-1:0] pend,
    output logic             valid,
    output iid_e             id
);

    logic [N_SRC-1:0] act;

    always_comb begin
        act   = ien & pend;
        valid = 1'b0;
        id    = IID_MSR;
        // walk from lowest rank up so the highest active source wins
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (act[PRIO_RANK[k]]) begin
                valid = 1'b1;
                id    = src_to_iid(PRIO_RANK[k]);
            end
        end
    end

endmodule

// File: rtl/uart_evt_track.sv
module uart_evt_track #(
    parameter int N_ERR = 4,
    parameter int N_MDM = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ERR-1:0] err_set,
    input  logic             err_clr,
    input  logic [N_MDM-1:0] mdm_in,
    input  logic             delta_clr,
    output logic [N_ERR-1:0] err_q,
    output logic [N_MDM-1:0] delta_q,
    output logic [N_MDM-1:0] mdm_prev
);

    typedef struct packed {
        logic [N_ERR-1:0] err;
        logic [N_MDM-1:0] delta;
        logic [N_MDM-1:0] prev;
        logic             primed;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.err    = (err_clr ? '0 : s_q.err) | err_set;
        s_d.delta  = (delta_clr ? '0 : s_q.delta)
                   | (s_q.primed ? (mdm_in ^ s_q.prev) : '0);
        s_d.prev   = mdm_in;
        s_d.primed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err_q    = s_q.err;
    assign delta_q  = s_q.delta;
    assign mdm_prev = s_q.prev;

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_reg_pkg::*;
#(
    parameter logic [15:0] DIV_RESET = 16'h0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    output logic          irq,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_ready,
    output logic          rx_pop,
    output logic [DW-1:0] tx_data,
    output logic          tx_push,
    input  logic          thr_empty,
    input  logic          tx_idle,
    input  logic [N_ERR-1:0] line_err,
    input  logic [N_MDM-1:0] modem_in,
    output logic [2*DW-1:0]  divisor,
    output logic [DW-1:0]    line_ctrl,
    output logic [MCR_W-1:0] modem_ctrl,
    output logic          fifo_en,
    output logic          rx_flush,
    output logic          tx_flush
);

    localparam int DLAB_BIT = DW - 1;

    typedef struct packed {
        logic [IER_W-1:0] ier;
        logic [DW-1:0]    lcr;
        logic [MCR_W-1:0] mcr;
        logic [DW-1:0]    scr;
        logic [DW-1:0]    dll;
        logic [DW-1:0]    dlm;
        logic             fifo;
        logic             thre_ip;
        logic             thr_prev;
    } regs_t;

    localparam regs_t REGS_RST = '{
        ier: '0, lcr: '0, mcr: '0, scr: '0,
        dll: DIV_RESET[DW-1:0], dlm: DIV_RESET[2*DW-1:DW],
        fifo: 1'b0, thre_ip: 1'b0, thr_prev: 1'b1
    };

    regs_t q, d;

    logic             dlab;
    logic             wr_thr, wr_ier, rd_iir, thr_rise, etb_on, thre_clr;
    logic [N_ERR-1:0] err_q;
    logic [N_MDM-1:0] delta_q, mdm_prev;
    logic [N_SRC-1:0] pend;
    logic             irq_valid;
    iid_e             irq_id;
    logic             thr_prev_q, thre_ip_q;

    assign dlab       = q.lcr[DLAB_BIT];
    assign thr_prev_q = q.thr_prev;
    assign thre_ip_q  = q.thre_ip;

    uart_evt_track #(.N_ERR(N_ERR), .N_MDM(N_MDM)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_set   (line_err),
        .err_clr   (rd_en && addr == OFS_LSR),
        .mdm_in    (modem_in),
        .delta_clr (rd_en && addr == OFS_MSR),
        .err_q     (err_q),
        .delta_q   (delta_q),
        .mdm_prev  (mdm_prev)
    );

    always_comb begin
        pend           = '0;
        pend[SRC_RDA]  = rx_ready;
        pend[SRC_THRE] = q.thre_ip;
        pend[SRC_RLS]  = |err_q;
        pend[SRC_MSR]  = |delta_q;
    end

    uart_irq_prio u_prio (
        .ien   (q.ier),
        .pend  (pend),
        .valid (irq_valid),
        .id    (irq_id)
    );

    // next state
    always_comb begin
        d        = q;
        wr_thr   = wr_en && addr == OFS_DATA && !dlab;
        wr_ier   = wr_en && addr == OFS_IER && !dlab;
        rd_iir   = rd_en && addr == OFS_IIR;
        thr_rise = thr_empty && !q.thr_prev;
        etb_on   = wr_ier && wdata[SRC_THRE] && !q.ier[SRC_THRE] && thr_empty;
        thre_clr = wr_thr || (rd_iir && irq_valid && irq_id == IID_THRE);

        d.thr_prev = thr_empty;
        d.thre_ip  = thr_rise || etb_on || (q.thre_ip && !thre_clr);

        if (wr_en) begin
            case (addr)
                OFS_DATA: if (dlab) d.dll = wdata;
                OFS_IER:  if (dlab) d.dlm = wdata;
                          else      d.ier = wdata[IER_W-1:0];
                OFS_IIR:  d.fifo = wdata[0];
                OFS_LCR:  d.lcr  = wdata;
                OFS_MCR:  d.mcr  = wdata[MCR_W-1:0];
                OFS_SCR:  d.scr  = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    // read mux
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_DATA: rdata = dlab ? q.dll : rx_data;
            OFS_IER:  rdata = dlab ? q.dlm : {{(DW-IER_W){1'b0}}, q.ier};
            OFS_IIR:  rdata = {{2{q.fifo}}, 2'b00, q.fifo & irq_id[2],
                               irq_id[1:0], ~irq_valid};
            OFS_LCR:  rdata = q.lcr;
            OFS_MCR:  rdata = {{(DW-MCR_W){1'b0}}, q.mcr};
            OFS_LSR:  rdata = {1'b0, tx_idle, thr_empty, err_q, rx_ready};
            OFS_MSR:  rdata = {modem_in, delta_q};
            default:  rdata = q.scr;
        endcase
    end

    assign irq        = irq_valid;
    assign rx_pop     = rd_en && addr == OFS_DATA && !dlab;
    assign tx_push    = wr_thr;
    assign tx_data    = wdata;
    assign divisor    = {q.dlm, q.dll};
    assign line_ctrl  = q.lcr;
    assign modem_ctrl = q.mcr;
    assign fifo_en    = q.fifo;
    assign rx_flush   = wr_en && addr == OFS_IIR && wdata[1];
    assign tx_flush   = wr_en && addr == OFS_IIR && wdata[2];

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  addr,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  rdata,
    input logic        irq,
    input logic [15:0] divisor,
    input logic        dlab,
    input logic        thr_empty,
    input logic        thr_prev,
    input logic        thre_ip,
    input logic [3:0]  err_q,
    input logic [3:0]  delta_q,
    input logic [3:0]  mdm_prev,
    input logic [3:0]  modem_in
);

    a_r2_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && dlab && (addr == 3'd0 || addr == 3'd1)) |=> $stable(divisor));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != 4'd0 && !(rd_en && addr == 3'd5))
        |=> ((err_q & $past(err_q)) == $past(err_q)));

    a_r11_delta_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd6 && modem_in == mdm_prev) |=> (delta_q == 4'd0));

    a_r9_thr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dlab && addr == 3'd0 && !(thr_empty && !thr_prev)) |=> !thre_ip);

    a_r7_pending_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd2) |-> (rdata[0] == !irq));

    a_r6_iid_bit3_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd2) |-> !rdata[3]);

endmodule

bind uart_regfile uart_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .irq       (irq),
    .divisor   (divisor),
    .dlab      (dlab),
    .thr_empty (thr_empty),
    .thr_prev  (thr_prev_q),
    .thre_ip   (thre_ip_q),
    .err_q     (err_q),
    .delta_q   (delta_q),
    .mdm_prev  (mdm_prev),
    .modem_in  (modem_in)
);

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        irq;
    logic [7:0]  rx_data = '0;
    logic        rx_ready = 1'b0;
    logic        rx_pop;
    logic [7:0]  tx_data;
    logic        tx_push;
    logic        thr_empty = 1'b0, tx_idle = 1'b0;
    logic [3:0]  line_err = '0, modem_in = '0;
    logic [15:0] divisor;
    logic [7:0]  line_ctrl;
    logic [4:0]  modem_ctrl;
    logic        fifo_en, rx_flush, tx_flush;

    int errors = 0;
    int checks = 0;

    logic [7:0] cap_rdata, cap_txd;
    logic       cap_irq, cap_pop, cap_push, cap_rxf, cap_txf;

    always #10 clk = ~clk;

    uart_regfile dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .irq(irq), .rx_data(rx_data),
        .rx_ready(rx_ready), .rx_pop(rx_pop), .tx_data(tx_data), .tx_push(tx_push),
        .thr_empty(thr_empty), .tx_idle(tx_idle), .line_err(line_err),
        .modem_in(modem_in), .divisor(divisor), .line_ctrl(line_ctrl),
        .modem_ctrl(modem_ctrl), .fifo_en(fifo_en), .rx_flush(rx_flush),
        .tx_flush(tx_flush)
    );

    // {is_write, offset, data, expected}
    localparam int NVEC = 12;
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 3'd3, 8'h03, 8'h00},
        {1'b0, 3'd3, 8'h00, 8'h03},
        {1'b1, 3'd4, 8'hFF, 8'h00},
        {1'b0, 3'd4, 8'h00, 8'h1F},
        {1'b1, 3'd7, 8'hA5, 8'h00},
        {1'b0, 3'd7, 8'h00, 8'hA5},
        {1'b1, 3'd1, 8'hFF, 8'h00},
        {1'b0, 3'd1, 8'h00, 8'h0F},
        {1'b1, 3'd1, 8'h05, 8'h00},
        {1'b0, 3'd1, 8'h00, 8'h05},
        {1'b1, 3'd7, 8'h3C, 8'h00},
        {1'b0, 3'd7, 8'h00, 8'h3C}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] dt);
        @(negedge clk);
        addr = a; wdata = dt; wr_en = 1'b1;
        #5;
        cap_push = tx_push; cap_txd = tx_data; cap_rxf = rx_flush; cap_txf = tx_flush;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #5;
        cap_rdata = rdata; cap_irq = irq; cap_pop = rx_pop;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd1); check("R1 ier", cap_rdata, 8'h00);
        rd(3'd3); check("R1 lcr", cap_rdata, 8'h00);
        rd(3'd4); check("R1 mcr", cap_rdata, 8'h00);
        rd(3'd7); check("R1 scr", cap_rdata, 8'h00);
        rd(3'd2); check("R1 iir", cap_rdata, 8'h01);
        check("R1 irq", cap_irq, 1'b0);
        check("R1 div", divisor, 16'h0000);
        check("R1 fifo", fifo_en, 1'b0);

        // table of register read-back (R4 for offset 1, R5 for the rest)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
            else begin
                rd(VEC[i][18:16]);
                check((VEC[i][18:16] == 3'd1) ? "R4 vec" : "R5 vec", cap_rdata, VEC[i][7:0]);
            end
        end

        // R2 divisor steering
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd(3'd0); check("R2 dll", cap_rdata, 8'h34);
        rd(3'd1); check("R2 dlm", cap_rdata, 8'h12);
        check("R2 div out", divisor, 16'h1234);
        wr(3'd3, 8'h03);
        rd(3'd1); check("R2 ier kept", cap_rdata, 8'h05);

        // R3 data port
        rx_data = 8'h5A;
        rd(3'd0); check("R3 rx byte", cap_rdata, 8'h5A); check("R3 pop", cap_pop, 1'b1);
        wr(3'd0, 8'h77); check("R3 push", cap_push, 1'b1); check("R3 txd", cap_txd, 8'h77);

        // R6 / R13 FIFO control
        wr(3'd2, 8'h07);
        check("R13 rx flush", cap_rxf, 1'b1); check("R13 tx flush", cap_txf, 1'b1);
        check("R6 fifo on", fifo_en, 1'b1);
        rd(3'd2); check("R6 iir fifo", cap_rdata, 8'hC1);
        wr(3'd2, 8'h00);
        check("R13 no flush", {cap_rxf, cap_txf}, 2'b00);
        rd(3'd2); check("R6 iir char", cap_rdata, 8'h01);

        // R8 priority walk, R7 pending flag
        wr(3'd1, 8'h0F);
        @(negedge clk);
        tx_idle = 1'b1; thr_empty = 1'b1; line_err = 4'b0001;
        modem_in = 4'b0001; rx_ready = 1'b1;
        @(negedge clk);
        line_err = 4'b0000;
        rd(3'd2); check("R8 rls first", cap_rdata, 8'h06); check("R7 irq", cap_irq, 1'b1);
        rd(3'd5); check("R10 lsr", cap_rdata, 8'h63);
        rd(3'd2); check("R8 rda second", cap_rdata, 8'h04);
        rx_ready = 1'b0;
        rd(3'd2); check("R8 thre third", cap_rdata, 8'h02);
        rd(3'd2); check("R9 thre cleared by iir read", cap_rdata, 8'h00);
        rd(3'd6); check("R11 msr", cap_rdata, 8'h11);
        rd(3'd2); check("R7 none pending", cap_rdata, 8'h01); check("R7 irq low", cap_irq, 1'b0);

        // R12 masking
        wr(3'd1, 8'h00);
        @(negedge clk); rx_ready = 1'b1;
        @(negedge clk); check("R12 masked irq", irq, 1'b0);
        rd(3'd2); check("R12 masked iir", cap_rdata, 8'h01);
        wr(3'd1, 8'h01);
        @(negedge clk); check("R12 enabled irq", irq, 1'b1);
        rd(3'd2); check("R12 enabled iir", cap_rdata, 8'h04);
        rx_ready = 1'b0;

        // R9 transmit-empty source
        wr(3'd1, 8'h02);
        rd(3'd2); check("R9 enable while empty", cap_rdata, 8'h02);
        wr(3'd0, 8'h11);
        rd(3'd2); check("R9 thr write clears", cap_rdata, 8'h01);
        @(negedge clk); thr_empty = 1'b0;
        @(negedge clk); thr_empty = 1'b1;
        @(negedge clk);
        rd(3'd2); check("R9 rise sets", cap_rdata, 8'h02);
        rd(3'd2); check("R9 read clears", cap_rdata, 8'h01);

        // R10 sticky errors
        wr(3'd1, 8'h00);
        @(negedge clk); line_err = 4'b1010;
        @(negedge clk); line_err = 4'b0000;
        rd(3'd5); check("R10 sticky", cap_rdata, 8'h74);
        rd(3'd5); check("R10 cleared", cap_rdata, 8'h60);

        // R11 modem change
        @(negedge clk); modem_in = 4'b1001;
        @(negedge clk);
        rd(3'd6); check("R11 dcd change", cap_rdata, 8'h98);
        rd(3'd6); check("R11 cleared", cap_rdata, 8'h90);

        // R1 reset again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 div after reset", divisor, 16'h0000);
        check("R1 lcr out", line_ctrl, 8'h00);
        check("R1 mcr out", {3'b000, modem_ctrl}, 8'h00);

        summary();
    end

endmodule